// File: doc/BRIEF.md
# Cache Transfer Acknowledge Generator

This block sits beside a cache tag lookup and decides, every cycle, whether the cache itself answers the processor's bus cycle with an active-low transfer acknowledge or leaves the answer to an external acknowledge source. It takes the tag-compare result and the stored valid and write-through bits for the addressed line, plus the processor's read/write type. It also takes a hit-enable control, an external acknowledge input that it registers on the rising clock, chip selects, a clear input and an active-low output enable.

A qualified hit with hit-enable set pulls the acknowledge low at once, whatever the external input says. In all other cases the registered external acknowledge passes through. In dedicated status mode, the stored bits steer the decision. There, an invalid line never acknowledges on a hit, and a processor write to a write-through line is held unacknowledged. In generic status mode, the stored bits are ignored. The acknowledge is held negated while the clear input is low, and from a clocked write until the next clocked read. The output is a value plus an enable pair, so a pad ring can build the three-state driver.

Top module: `xfer_ack_gen`

## Requirements
- R1: When `ack_oe_n_i` is high, `ack_en_o` is 0 and `ack_n_o` is 1.
- R2: The output is enabled only while the block is selected, that is `sel1_n_i` = 0 and `sel2_i` = 1. Either select inactive gives `ack_en_o` = 0 and `ack_n_o` = 1.
- R3: `ext_ack_n_i` is sampled on the rising clock. When it decides the output, a change of the input reaches `ack_n_o` only after the next rising edge.
- R4: With `hit_en_i` = 1 and a qualified hit, `ack_n_o` is 0 in the same cycle, even when the registered external acknowledge is 1.
- R5: With `hit_en_i` = 0, `ack_n_o` equals the registered external acknowledge, even when there is a qualified hit.
- R6: A qualified hit is `hit_i` = 1 together with either `vld_i` = 1 or `generic_mode_i` = 1. A hit on a line with `vld_i` = 0 in dedicated mode (`generic_mode_i` = 0) falls back to the external acknowledge.
- R7: In dedicated mode, `wt_i` = 1 with `wr_type_i` = 1 (write) forces `ack_n_o` to 1, overriding both a hit and an asserted external acknowledge. With `wr_type_i` = 0, or in generic mode, the `wt_i` bit has no effect.
- R8: While `clear_n_i` is 0, `ack_n_o` is 1.
- R9: After a rising edge on which the block is selected and `tag_wr_i` or `stat_wr_i` is 1, `ack_n_o` stays 1. This lasts until a rising edge on which the block is selected with both write strobes 0. From the cycle after that edge, normal decisions resume.
- R10: A rising edge with `rst_n` = 0 sets the registered external acknowledge to 1 and clears the pending-write condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| sel1_n_i | input | 1 | Select, active low |
| sel2_i | input | 1 | Select, active high |
| clear_n_i | input | 1 | Status clear, active low; blocks the acknowledge |
| tag_wr_i | input | 1 | Clocked tag write strobe, active high |
| stat_wr_i | input | 1 | Clocked status write strobe, active high |
| hit_i | input | 1 | Tag comparison equal |
| vld_i | input | 1 | Stored valid bit of the addressed line |
| wt_i | input | 1 | Stored write-through bit of the addressed line |
| generic_mode_i | input | 1 | 1: status bits carry no internal meaning |
| wr_type_i | input | 1 | Processor cycle type, 1 = write |
| hit_en_i | input | 1 | 1: a qualified hit may acknowledge directly |
| ext_ack_n_i | input | 1 | External acknowledge, active low, synchronous |
| ack_oe_n_i | input | 1 | Acknowledge output enable, active low |
| ack_n_o | output | 1 | Transfer acknowledge value, active low |
| ack_en_o | output | 1 | Drive enable for the acknowledge pad |

## Verification
The block has two pieces of state: the registered external acknowledge and the pending-write flag. A wrong external register shows up as an acknowledge that follows the input in the same cycle instead of one edge later, or as a stale value after reset. Either shows in the first cycle in which neither a hit nor a blocking condition decides. A pending-write flag that fails to set or clear shows as an acknowledge asserted right after a write, or one held negated past the first read edge. The bench sets a hit with hit-enable to expose this within one cycle.

// File: rtl/xfer_ack_pkg.sv
// Package: shared types for the transfer acknowledge generator.
// Assumes: nothing beyond IEEE 1800-2017.
package xfer_ack_pkg;

    // Which rule decided the acknowledge this cycle, in priority order.
    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,  // output not driven
        SRC_INVALID  = 3'd1,  // clear or pending write holds it negated
        SRC_WT_BLOCK = 3'd2,  // write to a write-through line
        SRC_HIT      = 3'd3,  // qualified hit with hit-enable
        SRC_EXT      = 3'd4   // registered external acknowledge
    } ack_src_e;

    localparam logic ACK_ASSERTED = 1'b0;
    localparam logic ACK_NEGATED  = 1'b1;

endpackage

// File: rtl/xfer_ack_sample.sv
// Module: registers the external acknowledge input on the rising clock.
// Assumes: input meets setup/hold to clk; synchronous active-low reset.
module xfer_ack_sample #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_ack_n_i,
    output logic ext_ack_n_q
);

    // Capture the external acknowledge every rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_ack_n_q <= RESET_VAL;
        else        ext_ack_n_q <= ext_ack_n_i;
    end

    // R10: the edge after a reset edge shows the negated value.
    a_r10_reset_negated: assert property (@(posedge clk)
        !rst_n |=> (ext_ack_n_q == RESET_VAL));

endmodule

// File: rtl/xfer_ack_guard.sv
// Module: tracks the conditions that make the acknowledge invalid, namely
// a low clear input, and the span from a clocked write to the next clocked read.
// Assumes: write strobes are sampled only while selected.
module xfer_ack_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic selected_i,
    input  logic clear_n_i,
    input  logic tag_wr_i,
    input  logic stat_wr_i,
    output logic invalid_o
);

    logic wr_seen;
    logic wr_pending_q;

    // Any write strobe counts as a clocked write.
    always_comb wr_seen = tag_wr_i | stat_wr_i;

    // Set on a selected write edge, clear on a selected read edge.
    always_ff @(posedge clk) begin
        if (!rst_n)          wr_pending_q <= 1'b0;
        else if (selected_i) wr_pending_q <= wr_seen;
    end

    // Invalid while cleared or while a write awaits a read.
    always_comb invalid_o = !clear_n_i || wr_pending_q;

    // R9: a selected write edge makes the next cycle invalid.
    a_r9_write_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (selected_i && wr_seen) |=> invalid_o);

    // R9: a selected read edge with clear high releases it.
    a_r9_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (selected_i && !wr_seen) |=> (invalid_o == !clear_n_i));

endmodule

// File: rtl/xfer_ack_decide.sv
// Module: priority decision for the acknowledge value.
// Order: off, invalid, write-through block, qualified hit, external.
// Assumes: ext_ack_n_q is already registered; purely combinational.
module xfer_ack_decide
    import xfer_ack_pkg::*;
(
    input  logic     drive_en_i,
    input  logic     invalid_i,
    input  logic     hit_i,
    input  logic     vld_i,
    input  logic     wt_i,
    input  logic     generic_mode_i,
    input  logic     wr_type_i,
    input  logic     hit_en_i,
    input  logic     ext_ack_n_q,
    output ack_src_e src_o,
    output logic     ack_n_o
);

    logic hit_ok;
    logic wt_block;

    // Valid bit only qualifies the hit in dedicated mode.
    always_comb hit_ok = hit_i && (generic_mode_i || vld_i);

    // Writes to write-through lines are not acknowledged in dedicated mode.
    always_comb wt_block = !generic_mode_i && wt_i && wr_type_i;

    // Pick the deciding rule by priority.
    always_comb begin
        if (!drive_en_i)            src_o = SRC_OFF;
        else if (invalid_i)         src_o = SRC_INVALID;
        else if (wt_block)          src_o = SRC_WT_BLOCK;
        else if (hit_en_i && hit_ok) src_o = SRC_HIT;
        else                        src_o = SRC_EXT;
    end

    // Map the rule to the active-low value.
    always_comb begin
        unique case (src_o)
            SRC_HIT: ack_n_o = ACK_ASSERTED;
            SRC_EXT: ack_n_o = ext_ack_n_q;
            default: ack_n_o = ACK_NEGATED;
        endcase
    end

endmodule

// File: rtl/xfer_ack_gen.sv
// Module: top of the transfer acknowledge generator. It joins the external
// sample register, the invalid guard and the priority decision, and it
// produces a value/enable pair for the three-state acknowledge pad.
// Assumes: tag compare and stored bits arrive as inputs for the current address.
module xfer_ack_gen
    import xfer_ack_pkg::*;
#(
    parameter logic EXT_RESET_VAL = ACK_NEGATED
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel1_n_i,
    input  logic sel2_i,
    input  logic clear_n_i,
    input  logic tag_wr_i,
    input  logic stat_wr_i,
    input  logic hit_i,
    input  logic vld_i,
    input  logic wt_i,
    input  logic generic_mode_i,
    input  logic wr_type_i,
    input  logic hit_en_i,
    input  logic ext_ack_n_i,
    input  logic ack_oe_n_i,
    output logic ack_n_o,
    output logic ack_en_o
);

    logic     selected;
    logic     ext_q;
    logic     invalid;
    ack_src_e src;

    // Both selects must be active for the block to be selected.
    always_comb selected = !sel1_n_i && sel2_i;

    // Pad drive enable needs the select and the output enable.
    always_comb ack_en_o = selected && !ack_oe_n_i;

    xfer_ack_sample #(.RESET_VAL(EXT_RESET_VAL)) u_sample (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_ack_n_i (ext_ack_n_i),
        .ext_ack_n_q (ext_q)
    );

    xfer_ack_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .selected_i (selected),
        .clear_n_i  (clear_n_i),
        .tag_wr_i   (tag_wr_i),
        .stat_wr_i  (stat_wr_i),
        .invalid_o  (invalid)
    );

    xfer_ack_decide u_decide (
        .drive_en_i     (ack_en_o),
        .invalid_i      (invalid),
        .hit_i          (hit_i),
        .vld_i          (vld_i),
        .wt_i           (wt_i),
        .generic_mode_i (generic_mode_i),
        .wr_type_i      (wr_type_i),
        .hit_en_i       (hit_en_i),
        .ext_ack_n_q    (ext_q),
        .src_o          (src),
        .ack_n_o        (ack_n_o)
    );

    // R1, R2: an undriven output carries the negated value.
    a_r1_off_negated: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_en_o |-> ack_n_o);

    // R8: clear low never lets the acknowledge assert.
    a_r8_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n_i |-> ack_n_o);

    // R7: write to a write-through line in dedicated mode stays negated.
    a_r7_wt_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!generic_mode_i && wt_i && wr_type_i) |-> ack_n_o);

    // R6: an invalid line in dedicated mode only acknowledges via the external path.
    a_r6_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!generic_mode_i && !vld_i && !ack_n_o) |-> !ext_q);

    // R3: on the external path the output follows the input one edge later.
    a_r3_ext_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && src == SRC_EXT) |-> (ack_n_o == $past(ext_ack_n_i)));

endmodule

// File: tb/xfer_ack_gen_bench.sv
module xfer_ack_gen_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic sel1_n, sel2, clear_n, tag_wr, stat_wr;
    logic hit, vld, wt, gen_mode, wr_type, hit_en, ext_n, oe_n;
    logic ack_n, ack_en;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    xfer_ack_gen u_xfer_ack_gen (
        .clk(clk), .rst_n(rst_n), .sel1_n_i(sel1_n), .sel2_i(sel2),
        .clear_n_i(clear_n), .tag_wr_i(tag_wr), .stat_wr_i(stat_wr),
        .hit_i(hit), .vld_i(vld), .wt_i(wt), .generic_mode_i(gen_mode),
        .wr_type_i(wr_type), .hit_en_i(hit_en), .ext_ack_n_i(ext_n),
        .ack_oe_n_i(oe_n), .ack_n_o(ack_n), .ack_en_o(ack_en)
    );

    task automatic check(input string req, input logic exp_n, input logic exp_en);
        n_run++;
        if (ack_n !== exp_n || ack_en !== exp_en) begin
            n_fail++;
            $display("FAIL %s: ack_n=%b ack_en=%b expected ack_n=%b ack_en=%b",
                     req, ack_n, ack_en, exp_n, exp_en);
        end
    endtask

    // Move to the next falling edge, where inputs change.
    task automatic fall();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        sel1_n = 0; sel2 = 1; clear_n = 1; tag_wr = 0; stat_wr = 0;
        hit = 0; vld = 1; wt = 0; gen_mode = 0; wr_type = 0;
        hit_en = 1; ext_n = 1; oe_n = 0;
    endtask

    // Set ext and let one rising edge register it.
    task automatic load_ext(input logic v);
        fall(); ext_n = v; fall(); #1;
    endtask

    task automatic t_reset();
        fall(); ext_n = 0; rst_n = 0; fall(); #1;
        check("R10 ext reg negated in reset", 1, 1);
        rst_n = 1; ext_n = 1; fall(); #1;
        check("R10 ext reg negated after reset", 1, 1);
    endtask

    task automatic t_disable();
        load_ext(0);
        check("R3 ext asserted path", 0, 1);
        oe_n = 1; #1; check("R1 oe high disables", 1, 0);
        oe_n = 0; sel1_n = 1; #1; check("R2 sel1 inactive", 1, 0);
        sel1_n = 0; sel2 = 0; #1; check("R2 sel2 inactive", 1, 0);
        sel2 = 1; #1; check("R2 selected again", 0, 1);
    endtask

    task automatic t_ext_latency();
        load_ext(1);
        fall(); ext_n = 0; #1;
        check("R3 no change before edge", 1, 1);
        fall(); #1;
        check("R3 change after edge", 0, 1);
    endtask

    task automatic t_hit();
        load_ext(1);
        hit = 1; vld = 1; hit_en = 1; #1;
        check("R4 hit overrides negated ext", 0, 1);
        hit_en = 0; #1;
        check("R5 hit_en low follows ext", 1, 1);
        load_ext(0);
        check("R5 hit_en low follows asserted ext", 0, 1);
        hit_en = 1; load_ext(1);
        vld = 0; #1;
        check("R6 invalid line no hit ack", 1, 1);
        gen_mode = 1; #1;
        check("R6 generic mode ignores vld", 0, 1);
        gen_mode = 0; vld = 1; hit = 0; #1;
    endtask

    task automatic t_wt();
        load_ext(0);
        hit = 1; vld = 1; wt = 1; wr_type = 1; #1;
        check("R7 wt write blocked", 1, 1);
        wr_type = 0; #1;
        check("R7 wt read acks", 0, 1);
        wr_type = 1; gen_mode = 1; #1;
        check("R7 generic mode ignores wt", 0, 1);
        gen_mode = 0; wt = 0; #1;
        check("R7 non-wt write acks", 0, 1);
        wr_type = 0; hit = 0;
    endtask

    task automatic t_clear();
        hit = 1; clear_n = 0; #1;
        check("R8 clear blocks", 1, 1);
        clear_n = 1; #1;
        check("R8 clear released", 0, 1);
        hit = 0;
    endtask

    task automatic t_write_read();
        hit = 1; load_ext(0);
        tag_wr = 1; fall(); tag_wr = 0; #1;
        check("R9 invalid after tag write", 1, 1);
        sel1_n = 1; fall(); sel1_n = 0; #1;
        check("R9 deselected edge keeps invalid", 1, 1);
        fall(); #1;
        check("R9 released after read edge", 0, 1);
        stat_wr = 1; fall(); stat_wr = 0; #1;
        check("R9 invalid after status write", 1, 1);
        fall(); #1;
        check("R9 status write released", 0, 1);
        hit = 0;
    endtask

    initial begin
        rst_n = 0; idle_inputs();
        repeat (2) fall();
        rst_n = 1;
        t_reset();
        t_disable();
        t_ext_latency();
        t_hit();
        t_wt();
        t_clear();
        t_write_read();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule